// File: doc/BRIEF.md
# Flash Control Register Interlock

This block holds the protected control bits of a flash rewrite controller. There are three such bits: a rewrite enable, a lock release and a second-level rewrite mode. The CPU reaches them over a simple register bus, and none of them can be set by a single store. Software must first write a 0 to the bit with a byte access. Its next bus write must then be a byte write of 1 to the same bit. That second write must happen while the NMI pin is high, and no interrupt acknowledge or DMA cycle may come between the two writes. A write that tries to set a bit and breaks any of these rules is refused and sets a sticky sequence-error flag.

Entering rewrite mode also requires a safe CPU clock. The clock divider setting must give at most the permitted frequency, and wait states must be on. The rewrite enable cannot be dropped by a plain byte write. It is cleared only by a 16-bit store to a fixed address, while the controller is in read-array mode and with a zero upper byte. An NMI or watchdog event clears every register bit and sends a one-cycle abort to the rewrite engine. In the second rewrite mode, a DMA request that arrives while the engine is busy raises a violation pulse.

Top module: `flash_ctl_guard`

## Requirements
- R1: After a synchronous active-low reset, the outputs rewrite_en, lock_rel, mode2, seq_err, abort and dma_viol are 0, and rdata reads 0 at both register addresses.
- R2: A guarded bit becomes 1 on the clock edge of an accepted sequence. The sequence is an 8-bit write of 0 to the bit, followed, as the next bus write, by an 8-bit write of 1 to the same bit. The guarded bits are: CTL0 (address 0x0057) bit 1 = rewrite enable, CTL0 bit 2 = lock release, and CTL1 (address 0x0055) bit 1 = second mode.
- R3: A 1-write to a guarded bit that is 0 is refused in two cases: no matching 0-write came before it, or another bus write (to any address) came between the two writes.
- R4: A 16-bit write (wr_wide=1) never arms the sequence and never sets a guarded bit. Any 16-bit write disarms a pending sequence.
- R5: An irq_ack or dma_req pulse after the 0-write, or in the cycle of the 1-write, voids the sequence, and the bit stays 0.
- R6: A 1-write made while nmi_pin is low is refused.
- R7: Setting the rewrite enable also needs wait_on=1 and SRC_MHZ <= MAX_MHZ × divisor. The divisor is clk_div, and a clk_div of 0 counts as 1. With the defaults, clk_div of 0 or 1 is refused and 2 is accepted.
- R8: The rewrite enable goes from 1 to 0 only through a 16-bit write to address 0x0057 with wdata[15:8]=0x00 and wdata bit 1 = 0, made while read_array=1. A byte write of 0 leaves it at 1.
- R9: An nmi_evt or wdt_evt pulse clears every register bit and the pending sequence on the next edge. It also raises abort for exactly one cycle.
- R10: seq_err (CTL0 bit 3) is set by any refused 1-write to a guarded bit that is 0. It is cleared by an 8-bit CTL0 write with bit 3 = 1. A 1-write to a bit that is already 1 is not an error.
- R11: CTL0 bit 0 reads as ready, which is rewrite_en AND NOT busy, and it follows busy in the same cycle.
- R12: dma_viol pulses high one cycle after a cycle in which dma_req, busy, rewrite_en and mode2 are all 1.
- R13: An 8-bit write of 0 to lock release or to second mode clears that bit on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_wide | input | 1 | 1 = 16-bit write, 0 = 8-bit write |
| addr | input | ADDR_W | Bus address, used for both write and read |
| wdata | input | 16 | Write data |
| rdata | output | 8 | Combinational read data at addr |
| irq_ack | input | 1 | Interrupt acknowledge cycle |
| dma_req | input | 1 | DMA transfer cycle |
| nmi_pin | input | 1 | NMI pin level |
| nmi_evt | input | 1 | NMI taken, forces reset |
| wdt_evt | input | 1 | Watchdog timeout, forces reset |
| read_array | input | 1 | Controller is in read-array mode |
| busy | input | 1 | Program or erase in progress |
| clk_div | input | DIV_W | CPU clock divider setting |
| wait_on | input | 1 | Wait-state bit |
| rewrite_en | output | 1 | Rewrite enable bit |
| lock_rel | output | 1 | Lock release bit |
| mode2 | output | 1 | Second rewrite mode bit |
| seq_err | output | 1 | Sticky sequence error |
| abort | output | 1 | One-cycle abort to the rewrite engine |
| dma_viol | output | 1 | DMA-while-busy violation pulse |

## Verification
The bench uses the default parameters: SRC_MHZ=20, MAX_MHZ=10, DIV_W=5, and register addresses 0x0057 and 0x0055. With these, the clock rule has its boundary between divider codes 1 and 2, and both sides of it are driven. Because the clear address equals the CTL0 address, the same location is exercised both by byte unlock writes and by the 16-bit clear store.

// File: rtl/flash_ctl_guard.sv
module flash_ctl_guard #(
  parameter int ADDR_W = 16,
  parameter int DIV_W = 5,
  parameter int SRC_MHZ = 20,
  parameter int MAX_MHZ = 10,
  parameter logic [ADDR_W-1:0] CTL0_ADDR = 'h57,
  parameter logic [ADDR_W-1:0] CTL1_ADDR = 'h55,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 'h57
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [7:0]        rdata,
  input  logic              irq_ack,
  input  logic              dma_req,
  input  logic              nmi_pin,
  input  logic              nmi_evt,
  input  logic              wdt_evt,
  input  logic              read_array,
  input  logic              busy,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              wait_on,
  output logic              rewrite_en,
  output logic              lock_rel,
  output logic              mode2,
  output logic              seq_err,
  output logic              abort,
  output logic              dma_viol
);
  localparam int B_RE = 1;
  localparam int B_LR = 2;
  localparam int B_SE = 3;
  localparam int B_M2 = 1;

  logic       armed;
  logic [2:0] arm_sel;

  wire sel0    = addr == CTL0_ADDR;
  wire sel1    = addr == CTL1_ADDR;
  wire byte_w0 = wr_en && !wr_wide && sel0;
  wire byte_w1 = wr_en && !wr_wide && sel1;
  wire intrude = irq_ack || dma_req;
  wire force_r = nmi_evt || wdt_evt;
  wire go      = armed && !intrude && nmi_pin;

  wire [DIV_W-1:0] div_eff = (clk_div == '0) ? DIV_W'(1) : clk_div;
  wire clk_ok = wait_on && (SRC_MHZ <= MAX_MHZ * int'(div_eff));

  wire try_re = byte_w0 && wdata[B_RE] && !rewrite_en;
  wire try_lr = byte_w0 && wdata[B_LR] && !lock_rel;
  wire try_m2 = byte_w1 && wdata[B_M2] && !mode2;
  wire ok_re  = try_re && go && arm_sel[0] && clk_ok;
  wire ok_lr  = try_lr && go && arm_sel[1];
  wire ok_m2  = try_m2 && go && arm_sel[2];
  wire reject = (try_re && !ok_re) || (try_lr && !ok_lr) || (try_m2 && !ok_m2);

  wire clr_re = wr_en && wr_wide && addr == CLR_ADDR && wdata[15:8] == 8'h00
                && !wdata[B_RE] && read_array;

  wire [2:0] zeros = {byte_w1 && !wdata[B_M2], byte_w0 && !wdata[B_LR], byte_w0 && !wdata[B_RE]};
  wire unused_bits = &{1'b0, wdata[7:4], wdata[0]};

  always_ff @(posedge clk) begin
    if (!rst_n || force_r) begin
      rewrite_en <= 1'b0;
      lock_rel   <= 1'b0;
      mode2      <= 1'b0;
      seq_err    <= 1'b0;
      armed      <= 1'b0;
      arm_sel    <= '0;
    end else begin
      if (ok_re) rewrite_en <= 1'b1;
      else if (clr_re) rewrite_en <= 1'b0;
      if (ok_lr) lock_rel <= 1'b1;
      else if (byte_w0 && !wdata[B_LR]) lock_rel <= 1'b0;
      if (ok_m2) mode2 <= 1'b1;
      else if (byte_w1 && !wdata[B_M2]) mode2 <= 1'b0;
      if (reject) seq_err <= 1'b1;
      else if (byte_w0 && wdata[B_SE]) seq_err <= 1'b0;
      if (wr_en) begin
        armed   <= !intrude && (zeros != '0);
        arm_sel <= zeros;
      end else if (intrude) begin
        armed <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort    <= 1'b0;
      dma_viol <= 1'b0;
    end else begin
      abort    <= force_r;
      dma_viol <= !force_r && rewrite_en && mode2 && busy && dma_req;
    end
  end

  assign rdata = sel0 ? {4'b0, seq_err, lock_rel, rewrite_en, rewrite_en && !busy}
               : sel1 ? {6'b0, mode2, 1'b0}
               : 8'h00;
endmodule

module flash_ctl_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic wr_wide,
  input logic irq_ack,
  input logic dma_req,
  input logic nmi_pin,
  input logic nmi_evt,
  input logic wdt_evt,
  input logic read_array,
  input logic busy,
  input logic wait_on,
  input logic rewrite_en,
  input logic lock_rel,
  input logic mode2,
  input logic seq_err,
  input logic abort,
  input logic dma_viol
);
  AST_FORCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_evt || wdt_evt) |=> abort && !rewrite_en && !lock_rel && !mode2 && !seq_err); // R9
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !nmi_evt && !wdt_evt) |=> !abort); // R9
  AST_SET_NEEDS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rewrite_en) || $rose(lock_rel) || $rose(mode2)) |-> $past(nmi_pin)); // R6
  AST_SET_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rewrite_en) || $rose(lock_rel) || $rose(mode2)) |-> $past(wr_en) && !$past(wr_wide)); // R4
  AST_SET_NO_INTRUDE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rewrite_en) || $rose(lock_rel) || $rose(mode2)) |-> !$past(irq_ack) && !$past(dma_req)); // R5
  AST_RE_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rewrite_en) |-> $past(wait_on)); // R7
  AST_RE_CLEAR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rewrite_en) |-> ($past(wr_en) && $past(wr_wide) && $past(read_array)) || $past(nmi_evt) || $past(wdt_evt)); // R8
  AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_viol |-> $past(busy) && $past(dma_req) && $past(mode2)); // R12
endmodule

bind flash_ctl_guard flash_ctl_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide), .irq_ack(irq_ack),
  .dma_req(dma_req), .nmi_pin(nmi_pin), .nmi_evt(nmi_evt), .wdt_evt(wdt_evt),
  .read_array(read_array), .busy(busy), .wait_on(wait_on), .rewrite_en(rewrite_en),
  .lock_rel(lock_rel), .mode2(mode2), .seq_err(seq_err), .abort(abort), .dma_viol(dma_viol)
);

// File: tb/sim_flash_ctl_guard.sv
module sim_flash_ctl_guard;
  localparam logic [15:0] A0 = 16'h0057;
  localparam logic [15:0] A1 = 16'h0055;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_wide = 1'b0;
  logic [15:0] addr = A0;
  logic [15:0] wdata = '0;
  logic [7:0] rdata;
  logic irq_ack = 1'b0, dma_req = 1'b0, nmi_pin = 1'b1, nmi_evt = 1'b0, wdt_evt = 1'b0;
  logic read_array = 1'b0, busy = 1'b0, wait_on = 1'b1;
  logic [4:0] clk_div = 5'd2;
  logic rewrite_en, lock_rel, mode2, seq_err, abort, dma_viol;
  int total = 0, fails = 0;

  always #10 clk = ~clk;

  flash_ctl_guard u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_ack(irq_ack), .dma_req(dma_req), .nmi_pin(nmi_pin), .nmi_evt(nmi_evt),
    .wdt_evt(wdt_evt), .read_array(read_array), .busy(busy), .clk_div(clk_div), .wait_on(wait_on),
    .rewrite_en(rewrite_en), .lock_rel(lock_rel), .mode2(mode2), .seq_err(seq_err),
    .abort(abort), .dma_viol(dma_viol)
  );

  // {wide, sel CTL1, data, nmi, irq, expect CTL0, expect CTL1}
  localparam logic [27:0] TBL [0:NV-1] = '{
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00},  // R2 arm
    {1'b0, 1'b0, 8'h02, 1'b1, 1'b0, 8'h03, 8'h00},  // R2 rewrite enable set
    {1'b0, 1'b0, 8'h06, 1'b1, 1'b0, 8'h07, 8'h00},  // R2 lock release set
    {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h07, 8'h00},
    {1'b0, 1'b1, 8'h02, 1'b0, 1'b0, 8'h0F, 8'h00},  // R6 nmi low
    {1'b0, 1'b0, 8'h0E, 1'b1, 1'b0, 8'h07, 8'h00},  // R10 clear, 1 to set bits no error
    {1'b0, 1'b1, 8'h02, 1'b1, 1'b0, 8'h0F, 8'h00},  // R3 lone 1-write
    {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h0F, 8'h00},
    {1'b0, 1'b1, 8'h02, 1'b1, 1'b1, 8'h0F, 8'h00},  // R5 irq in 1-write
    {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h0F, 8'h00},
    {1'b0, 1'b1, 8'h02, 1'b1, 1'b0, 8'h0F, 8'h02},  // R2 mode2 set
    {1'b0, 1'b0, 8'h0A, 1'b1, 1'b0, 8'h03, 8'h02},  // R13 lock release cleared
    {1'b1, 1'b0, 8'h04, 1'b1, 1'b0, 8'h03, 8'h02},  // R4 wide write disarms
    {1'b0, 1'b0, 8'h06, 1'b1, 1'b0, 8'h0B, 8'h02}   // R4 refused after wide
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic wide, input logic [15:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_wide = wide; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wr_wide = 1'b0; irq_ack = 1'b0; dma_req = 1'b0; addr = A0;
  endtask

  task automatic rd(input string tag, input logic [7:0] e0, input logic [7:0] e1);
    addr = A0; #1 chk(tag, rdata, e0);
    addr = A1; #1 chk(tag, rdata, e1);
    addr = A0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic set_re();
    wr(1'b0, A0, 16'h0000); wr(1'b0, A0, 16'h0002);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 outs", {2'b0, rewrite_en, lock_rel, mode2, seq_err, abort, dma_viol}, 8'h00);
    rd("R1 regs", 8'h00, 8'h00);

    for (int i = 0; i < NV; i++) begin
      nmi_pin = TBL[i][17]; irq_ack = TBL[i][16];
      wr(TBL[i][27], TBL[i][26] ? A1 : A0, {8'h00, TBL[i][25:18]});
      nmi_pin = 1'b1;
      rd($sformatf("table row %0d", i), TBL[i][15:8], TBL[i][7:0]);
    end

    do_reset();
    clk_div = 5'd1; set_re();
    rd("R7 div 1 refused", 8'h08, 8'h00);
    clk_div = 5'd0; wr(1'b0, A0, 16'h0008); set_re();
    rd("R7 div 0 refused", 8'h08, 8'h00);
    clk_div = 5'd2; wait_on = 1'b0; wr(1'b0, A0, 16'h0008); set_re();
    rd("R7 wait off refused", 8'h08, 8'h00);
    wait_on = 1'b1; wr(1'b0, A0, 16'h0008); set_re();
    rd("R7 div 2 accepted", 8'h03, 8'h00);

    wr(1'b0, A0, 16'h0000);
    rd("R8 byte zero keeps enable", 8'h03, 8'h00);
    wr(1'b1, A0, 16'h0000);
    rd("R8 no read array keeps", 8'h03, 8'h00);
    read_array = 1'b1;
    wr(1'b1, A0, 16'h0100);
    rd("R8 upper byte nonzero keeps", 8'h03, 8'h00);
    wr(1'b1, A0, 16'h0000);
    rd("R8 clear accepted", 8'h00, 8'h00);
    read_array = 1'b0;

    wr(1'b0, A0, 16'h0000); wr(1'b0, 16'h0100, 16'h0000); wr(1'b0, A0, 16'h0002);
    rd("R3 other write between", 8'h08, 8'h00);
    wr(1'b0, A0, 16'h0008);
    wr(1'b0, A0, 16'h0000);
    dma_req = 1'b1; @(negedge clk); dma_req = 1'b0;
    wr(1'b0, A0, 16'h0002);
    rd("R5 dma between", 8'h08, 8'h00);
    wr(1'b0, A0, 16'h0008);
    wr(1'b1, A0, 16'h0000); wr(1'b0, A0, 16'h0002);
    rd("R4 wide zero does not arm", 8'h08, 8'h00);
    wr(1'b0, A0, 16'h0008);

    set_re();
    busy = 1'b1; #1 addr = A0; #1 chk("R11 busy ready low", rdata, 8'h02);
    busy = 1'b0; #1 chk("R11 idle ready high", rdata, 8'h03);
    wr(1'b0, A1, 16'h0000); wr(1'b0, A1, 16'h0002);
    rd("R2 mode2 set", 8'h03, 8'h02);
    dma_req = 1'b1; @(negedge clk); dma_req = 1'b0;
    chk("R12 idle no viol", {7'b0, dma_viol}, 8'h00);
    busy = 1'b1; dma_req = 1'b1; @(negedge clk); dma_req = 1'b0;
    chk("R12 viol pulse", {7'b0, dma_viol}, 8'h01);
    @(negedge clk);
    chk("R12 viol ends", {7'b0, dma_viol}, 8'h00);
    busy = 1'b0;
    wr(1'b0, A1, 16'h0000);
    rd("R13 mode2 cleared", 8'h03, 8'h00);

    wr(1'b0, A1, 16'h0000); wr(1'b0, A1, 16'h0002);
    wr(1'b0, A0, 16'h0000);
    wdt_evt = 1'b1; @(negedge clk); wdt_evt = 1'b0;
    chk("R9 wdt abort", {7'b0, abort}, 8'h01);
    rd("R9 wdt clears", 8'h00, 8'h00);
    @(negedge clk);
    chk("R9 abort one cycle", {7'b0, abort}, 8'h00);
    wr(1'b0, A0, 16'h0002);
    rd("R9 sequence disarmed", 8'h08, 8'h00);
    set_re();
    nmi_evt = 1'b1; @(negedge clk); nmi_evt = 1'b0;
    chk("R9 nmi abort", {7'b0, abort}, 8'h01);
    rd("R9 nmi clears", 8'h00, 8'h00);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule